// File: doc/BRIEF.md
# Synthesizer Phase Detector Control

This block is the digital control stage that sits between the two programmable dividers of a channel synthesizer and its analog charge pump. It accepts a one-cycle pulse from the divided reference and a one-cycle pulse from the divided oscillator. From these it drives pump-up, pump-down and high-impedance controls for the pump. A two-bit test field can force the pump outputs. A polarity bit swaps which input counts as pushing the loop upward.

A slot policy stage sits alongside the detector. From the slot state (transmit active, receive active or neither) and the per-slot divider mode bits, it decides whether the dividers stay powered and whether the loop is held open. When the loop is held open, the pump floats and the oscillator keeps its last tuning voltage. This lets the oscillator be modulated directly during transmit. The analog pump, the loop filter and the oscillator are outside this block.

Top module: `synth_pfd_ctrl`

## Requirements
- R1: After reset both detector flops are clear, so with the pump powered, the normal test code 2'b11 and no slot active, `pump_up` and `pump_dn` read 0 and `pump_hiz` reads 0.
- R2: With `cp_power`=1 and the loop not held, `cp_test` selects the pump output. 2'b00 gives hiz=1, up=0, dn=0. 2'b01 gives up=1, dn=0, hiz=0. 2'b10 gives dn=1, up=0, hiz=0. 2'b11 gives hiz=0 with up and dn taken from the detector.
- R3: With `cp_power`=0, `pump_hiz`=1 and `pump_up`=`pump_dn`=0 for every `cp_test` code and slot state.
- R4: Each detector input pulse sets its own flop on the next clock edge. When both flops are set, both clear on the following edge, and pulses arriving in that clearing cycle are ignored. If one input leads by d cycles (d≥0), its flop stays high for d+1 cycles and the lagging flop stays high for 1 cycle.
- R5: With `pd_sense`=0, `pump_up` follows the oscillator flop and `pump_dn` follows the reference flop. With `pd_sense`=1, the two are swapped.
- R6: `pump_up` and `pump_dn` are never both high from the detector for two consecutive cycles.
- R7: While `tx_active`=1 (which takes priority over `rx_active`), `loop_hold`=1, the pump is high-impedance with up=dn=0, and `div_power` equals `tx_div_mode`.
- R8: While only `rx_active`=1, `rx_div_mode` selects the outcome. 2'b00 gives div_power=0 and loop_hold=1. 2'b01 gives div_power=1 and loop_hold=1. 2'b10 and 2'b11 give div_power=1 and loop_hold=0. A held loop floats the pump.
- R9: With neither slot active, `div_power`=1 and `loop_hold`=0.
- R10: While `div_power`=0, both detector flops are cleared and input pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse from the reference divider |
| osc_pulse | input | 1 | One-cycle pulse from the oscillator divider |
| tx_active | input | 1 | Active transmit slot |
| rx_active | input | 1 | Active receive slot |
| cp_test | input | 2 | Pump test code |
| pd_sense | input | 1 | Detector polarity |
| cp_power | input | 1 | Charge pump powered |
| tx_div_mode | input | 1 | Divider power choice in transmit slots |
| rx_div_mode | input | 2 | Divider/loop choice in receive slots |
| pump_up | output | 1 | Pump-up control |
| pump_dn | output | 1 | Pump-down control |
| pump_hiz | output | 1 | Pump output floating |
| div_power | output | 1 | Divider power enable |
| loop_hold | output | 1 | Loop held open (flywheel) |

## Verification
A detector flop that misses its set or clear shows at the pump pins as a pulse that is too long, too short or missing. This is visible one cycle after the affected edge, so the bench counts high cycles per input lead and compares them against d+1 and 1. A stale flop left over from a powered-down interval appears as a lone pump pulse in the first idle cycle afterwards. Slot-policy faults appear at once on `div_power`, `loop_hold` and the pump float control. For this reason every slot, mode and test-code combination is swept.

// File: rtl/synth_pfd_pkg.sv
package synth_pfd_pkg;
   typedef enum logic [1:0] {
      CP_FLOAT = 2'b00,
      CP_UP    = 2'b01,
      CP_DOWN  = 2'b10,
      CP_RUN   = 2'b11
   } cp_test_e;

   typedef struct packed {
      logic up;
      logic dn;
      logic hiz;
   } pump_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
   input  logic clk,
   input  logic rst_n,
   input  logic div_en,
   input  logic ref_pulse,
   input  logic osc_pulse,
   output logic ref_q,
   output logic osc_q
);
   logic both;
   assign both = ref_q & osc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         osc_q <= 1'b0;
      end else if (!div_en || both) begin
         ref_q <= 1'b0;
         osc_q <= 1'b0;
      end else begin
         ref_q <= ref_q | ref_pulse;
         osc_q <= osc_q | osc_pulse;
      end
   end

   // R6
   overlap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && osc_q) |=> !(ref_q && osc_q));

   // R10
   div_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_en |=> (!ref_q && !osc_q));

   // R4
   ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_en && ref_pulse && !(ref_q && osc_q)) |=> ref_q);
endmodule

// File: rtl/slot_policy.sv
module slot_policy #(
   parameter int RXM_W = 2
) (
   input  logic             tx_active,
   input  logic             rx_active,
   input  logic             tx_div_mode,
   input  logic [RXM_W-1:0] rx_div_mode,
   output logic             div_en,
   output logic             hold
);
   initial begin
      if (RXM_W != 2) $error("slot_policy: RXM_W must be 2");
   end

   always_comb begin
      if (tx_active) begin
         div_en = tx_div_mode;
         hold   = 1'b1;
      end else if (rx_active) begin
         div_en = |rx_div_mode;
         hold   = ~rx_div_mode[RXM_W-1];
      end else begin
         div_en = 1'b1;
         hold   = 1'b0;
      end
   end
endmodule

// File: rtl/pump_drive.sv
module pump_drive
   import synth_pfd_pkg::*;
#(
   parameter int OUT_REG = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_q,
   input  logic       osc_q,
   input  logic       sense,
   input  logic [1:0] test,
   input  logic       power,
   input  logic       hold,
   output pump_t      pump
);
   pump_t nxt;
   logic  det_up, det_dn;

   assign det_up = sense ? ref_q : osc_q;
   assign det_dn = sense ? osc_q : ref_q;

   always_comb begin
      nxt = '{up: 1'b0, dn: 1'b0, hiz: 1'b1};
      if (power && !hold) begin
         unique case (cp_test_e'(test))
            CP_FLOAT: nxt = '{up: 1'b0,   dn: 1'b0,   hiz: 1'b1};
            CP_UP:    nxt = '{up: 1'b1,   dn: 1'b0,   hiz: 1'b0};
            CP_DOWN:  nxt = '{up: 1'b0,   dn: 1'b1,   hiz: 1'b0};
            CP_RUN:   nxt = '{up: det_up, dn: det_dn, hiz: 1'b0};
            default:  nxt = '{up: 1'b0,   dn: 1'b0,   hiz: 1'b1};
         endcase
      end
   end

   generate
      if (OUT_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pump <= '{up: 1'b0, dn: 1'b0, hiz: 1'b1};
            else        pump <= nxt;
         end
      end else begin : g_comb
         assign pump = nxt;
      end
   endgenerate
endmodule

// File: rtl/synth_pfd_ctrl.sv
module synth_pfd_ctrl
   import synth_pfd_pkg::*;
#(
   parameter int TEST_W  = 2,
   parameter int RXM_W   = 2,
   parameter int OUT_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic             osc_pulse,
   input  logic             tx_active,
   input  logic             rx_active,
   input  logic [TEST_W-1:0] cp_test,
   input  logic             pd_sense,
   input  logic             cp_power,
   input  logic             tx_div_mode,
   input  logic [RXM_W-1:0] rx_div_mode,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             pump_hiz,
   output logic             div_power,
   output logic             loop_hold
);
   initial begin
      if (TEST_W != 2) $error("synth_pfd_ctrl: TEST_W must be 2");
      if (OUT_REG != 0 && OUT_REG != 1) $error("synth_pfd_ctrl: OUT_REG must be 0 or 1");
   end

   logic  div_en, hold, ref_q, osc_q;
   pump_t pump;

   slot_policy #(.RXM_W(RXM_W)) u_policy (
      .tx_active(tx_active), .rx_active(rx_active),
      .tx_div_mode(tx_div_mode), .rx_div_mode(rx_div_mode),
      .div_en(div_en), .hold(hold)
   );

   pfd_core u_core (
      .clk(clk), .rst_n(rst_n), .div_en(div_en),
      .ref_pulse(ref_pulse), .osc_pulse(osc_pulse),
      .ref_q(ref_q), .osc_q(osc_q)
   );

   pump_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk(clk), .rst_n(rst_n), .ref_q(ref_q), .osc_q(osc_q),
      .sense(pd_sense), .test(cp_test[1:0]), .power(cp_power),
      .hold(hold), .pump(pump)
   );

   assign pump_up   = pump.up;
   assign pump_dn   = pump.dn;
   assign pump_hiz  = pump.hiz;
   assign div_power = div_en;
   assign loop_hold = hold;

   generate
      if (OUT_REG == 0) begin : g_chk
         // R7
         tx_flywheel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_active |-> (pump_hiz && !pump_up && !pump_dn));
         // R3
         cp_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cp_power |-> (pump_hiz && !pump_up && !pump_dn));
         // R6
         no_long_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pump_up && pump_dn) |=> !(pump_up && pump_dn && $stable(cp_test)));
      end
   endgenerate
endmodule

// File: tb/synth_pfd_ctrl_test.sv
module synth_pfd_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 0, osc_pulse = 0, tx_active = 0, rx_active = 0;
   logic [1:0] cp_test = 2'b11;
   logic pd_sense = 0, cp_power = 1, tx_div_mode = 0;
   logic [1:0] rx_div_mode = 2'b00;
   logic pump_up, pump_dn, pump_hiz, div_power, loop_hold;
   int checks = 0, failures = 0;

   always #2 clk = ~clk;

   synth_pfd_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .osc_pulse(osc_pulse),
      .tx_active(tx_active), .rx_active(rx_active), .cp_test(cp_test),
      .pd_sense(pd_sense), .cp_power(cp_power), .tx_div_mode(tx_div_mode),
      .rx_div_mode(rx_div_mode), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_hiz(pump_hiz), .div_power(div_power), .loop_hold(loop_hold)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // lead input fires at step 0, the other at step d; count high samples
   task automatic run_pfd(input logic sense, input logic ref_leads, input int d);
      int up_n = 0, dn_n = 0, both_n = 0;
      int lead_n, lag_n;
      pd_sense = sense;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         ref_pulse = ref_leads ? (i == 0) : (i == d);
         osc_pulse = ref_leads ? (i == d) : (i == 0);
         #1;
         if (i > 0) begin
            up_n += pump_up;
            dn_n += pump_dn;
            both_n += (pump_up & pump_dn);
         end
      end
      ref_pulse = 0; osc_pulse = 0;
      lead_n = d + 1;
      lag_n = 1;
      // R4 R5: ref flop drives dn when sense=0, up when sense=1
      if (ref_leads ^ sense) begin
         check("R4/R5 up count", up_n, lag_n);
         check("R4/R5 dn count", dn_n, lead_n);
      end else begin
         check("R4/R5 up count", up_n, lead_n);
         check("R4/R5 dn count", dn_n, lag_n);
      end
      check("R6 overlap cycles", both_n, 1);
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1
      check("R1 up after reset", pump_up, 0);
      check("R1 dn after reset", pump_dn, 0);
      check("R1 hiz after reset", pump_hiz, 0);
      @(negedge clk) rst_n = 1;
      @(negedge clk); #1;
      check("R1 up idle", pump_up, 0);
      check("R9 div_power idle", div_power, 1);
      check("R9 loop_hold idle", loop_hold, 0);

      // R4 R5 R6 sweep
      for (int s = 0; s < 2; s++)
         for (int l = 0; l < 2; l++)
            for (int d = 0; d < 5; d++)
               run_pfd(s[0], l[0], d);

      // R2 R3 R7 R8 R9: sweep configuration and slot states
      for (int p = 0; p < 2; p++)
         for (int t = 0; t < 4; t++)
            for (int slot = 0; slot < 3; slot++)
               for (int m = 0; m < 4; m++) begin
                  logic exp_hold, exp_div, eu, ed, eh;
                  @(negedge clk);
                  cp_power = p[0]; cp_test = t[1:0];
                  tx_active = (slot == 1); rx_active = (slot == 2);
                  tx_div_mode = m[0]; rx_div_mode = m[1:0];
                  #1;
                  if (slot == 1) begin exp_hold = 1; exp_div = m[0]; end
                  else if (slot == 2) begin exp_hold = ~m[1]; exp_div = (m != 0); end
                  else begin exp_hold = 0; exp_div = 1; end
                  eu = 0; ed = 0; eh = 1;
                  if (p == 1 && !exp_hold) begin
                     eh = (t == 0);
                     eu = (t == 1);
                     ed = (t == 2);
                  end
                  check("R7/R8/R9 loop_hold", loop_hold, exp_hold);
                  check("R7/R8/R9 div_power", div_power, exp_div);
                  check("R2/R3 pump_up", pump_up, eu);
                  check("R2/R3 pump_dn", pump_dn, ed);
                  check("R2/R3 pump_hiz", pump_hiz, eh);
               end

      // R7: tx takes priority over rx
      @(negedge clk);
      cp_power = 1; cp_test = 2'b01; tx_active = 1; rx_active = 1;
      tx_div_mode = 0; rx_div_mode = 2'b11; #1;
      check("R7 priority hold", loop_hold, 1);
      check("R7 priority div", div_power, 0);
      check("R7 priority up", pump_up, 0);

      // R10: divider power-down clears a pending ref flop
      @(negedge clk);
      tx_active = 0; rx_active = 0; cp_test = 2'b11; pd_sense = 0;
      ref_pulse = 1;
      @(negedge clk); ref_pulse = 0; #1;
      check("R10 ref pending dn", pump_dn, 1);
      rx_active = 1; rx_div_mode = 2'b00; osc_pulse = 1;
      @(negedge clk); osc_pulse = 0; #1;
      check("R10 div off", div_power, 0);
      rx_active = 0;
      @(negedge clk); #1;
      check("R10 dn cleared", pump_dn, 0);
      check("R10 pulse ignored", pump_up, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule